// File: doc/BRIEF.md
# Master Serial Port Frame Generator

This block is the clock-owning side of a synchronous, full-duplex serial link between a converter front end and a host signal processor. It divides the system clock into a serial bit clock and groups the bit clocks into fixed-length frames. Each frame it sends one 16-bit word to the host and collects one 16-bit word from it. The parallel side sees a load strobe when the outgoing word is taken, and a valid strobe when a full incoming word has been assembled.

Two frame-sync styles exist. In the early style a single bit-clock-wide pulse marks the slot just before the data. In the late style the sync line is held for the whole data window and acts as a select. A mode pin picks the style. It is watched only while reset is held, and the value it has when reset lifts stays in force until the next reset.

Slot numbering used below: every rising bit-clock edge opens a new slot. Slot 0 opens each frame, slots 1 to 16 carry data, and slots 17 to 255 are idle.

Top module: `sport_frame_master`

## Requirements
- R1: `sclk_o` is the system clock divided by 18. It is high for 9 system cycles and low for 9. Its first rising edge comes at the first system clock edge after reset is released.
- R2: A frame lasts 256 bit clocks, which is 4608 system cycles. `tx_load_o` pulses for one system cycle at the edge that opens slot 0 of every frame, and `tx_word_i` is captured at that edge.
- R3: The captured word is sent on `sdo_o` in slots 1 to 16, MSB first. Slot k carries bit 16-k, and `sdo_o` changes only at rising bit-clock edges.
- R4: When the early style is in force, `fsync_o` is high during slot 0 only.
- R5: When the late style is in force, `fsync_o` is high during slots 1 to 16 only.
- R6: `sdo_o` is low during slot 0 and during slots 17 to 255.
- R7: `sdi_i` is sampled at the falling bit-clock edge of slots 1 to 16, MSB first. At the falling edge of slot 16, `rx_word_o` takes the assembled word and `rx_valid_o` pulses for one system cycle. Otherwise `rx_word_o` holds its value.
- R8: `mode_late_i` is sampled on every clock while `rst_n` is low. A value of 1 selects the late style and 0 selects the early style. The value present when reset is released stays in force, and later changes on the pin have no effect on `fsync_o`.
- R9: While reset is held, `sclk_o`, `fsync_o`, `sdo_o`, `tx_load_o`, `rx_valid_o` and `rx_word_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_late_i | input | 1 | Frame-sync style select, sampled only during reset (1 = late, 0 = early) |
| tx_word_i | input | 16 | Word to transmit, taken at frame start |
| tx_load_o | output | 1 | One-cycle strobe when `tx_word_i` is captured |
| rx_word_o | output | 16 | Last complete received word |
| rx_valid_o | output | 1 | One-cycle strobe when `rx_word_o` is updated |
| sclk_o | output | 1 | Serial bit clock |
| fsync_o | output | 1 | Frame sync |
| sdo_o | output | 1 | Serial data to host |
| sdi_i | input | 1 | Serial data from host |

## Verification
Several actions land on the same system edge. At the edge that opens slot 0, the transmit word is captured, `tx_load_o` fires, the early-style sync rises and the data line is forced idle. At the falling edge of slot 16, the last received bit is shifted in and delivered while the late-style sync is still high. The bench changes `tx_word_i` and `sdi_i` on every cycle, including the capture and sampling cycles, and runs one reset in each style. A behavioural model, driven only by a cycle count since reset, predicts every output on every clock. A wrong capture edge, a slot off by one or a sync that misses its window therefore shows up as a mismatch at that exact cycle.

// File: rtl/sport_pkg.sv
package sport_pkg;
    typedef enum logic {
        FS_EARLY = 1'b0,
        FS_LATE  = 1'b1
    } fs_mode_e;
endpackage

// File: rtl/sport_clkdiv.sv
module sport_clkdiv #(
    parameter int DIV = 18
) (
    input  logic clk,
    input  logic rst_n,
    output logic sclk_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int HALF = DIV / 2;
    localparam int PH_W = $clog2(DIV);

    typedef struct packed {
        logic [PH_W-1:0] phase;
        logic            sclk;
    } div_st_t;

    div_st_t div_d, div_q;

    always_comb begin
        div_d = div_q;
        if (div_q.phase == PH_W'(DIV - 1))
            div_d.phase = '0;
        else
            div_d.phase = div_q.phase + 1'b1;
        div_d.sclk = (div_d.phase < PH_W'(HALF));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q.phase <= PH_W'(DIV - 1);
            div_q.sclk  <= 1'b0;
        end else begin
            div_q <= div_d;
        end
    end

    assign sclk_o = div_q.sclk;
    assign rise_o = (div_q.phase == PH_W'(DIV - 1));
    assign fall_o = (div_q.phase == PH_W'(HALF - 1));

    p_rise_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |-> (!sclk_o ##1 sclk_o));
    p_fall_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |-> (sclk_o ##1 !sclk_o));
endmodule

// File: rtl/sport_framer.sv
module sport_framer
    import sport_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int FRAME_SLOTS = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_late_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              sclk_i,
    input  logic [WORD_W-1:0] tx_word_i,
    input  logic              sdi_i,
    output logic              fsync_o,
    output logic              sdo_o,
    output logic              tx_load_o,
    output logic [WORD_W-1:0] rx_word_o,
    output logic              rx_valid_o
);
    localparam int SLOT_W = $clog2(FRAME_SLOTS);

    typedef struct packed {
        fs_mode_e          mode;
        logic [SLOT_W-1:0] slot;
        logic [WORD_W-1:0] txsh;
        logic [WORD_W-1:0] rxsh;
        logic [WORD_W-1:0] rx_word;
        logic              fsync;
        logic              sdo;
        logic              tx_load;
        logic              rx_valid;
    } frm_st_t;

    frm_st_t frm_d, frm_q;
    logic [SLOT_W-1:0] slot_nx;
    logic              data_nx;
    logic              data_now;

    always_comb begin
        frm_d          = frm_q;
        frm_d.tx_load  = 1'b0;
        frm_d.rx_valid = 1'b0;
        slot_nx        = frm_q.slot;
        data_nx        = 1'b0;
        data_now       = (frm_q.slot != '0) && (frm_q.slot <= SLOT_W'(WORD_W));

        if (rise_i) begin
            if (frm_q.slot == SLOT_W'(FRAME_SLOTS - 1))
                slot_nx = '0;
            else
                slot_nx = frm_q.slot + 1'b1;
            data_nx    = (slot_nx != '0) && (slot_nx <= SLOT_W'(WORD_W));
            frm_d.slot = slot_nx;
            if (slot_nx == '0) begin
                frm_d.txsh    = tx_word_i;
                frm_d.tx_load = 1'b1;
            end
            if (data_nx) begin
                frm_d.sdo  = frm_q.txsh[WORD_W-1];
                frm_d.txsh = {frm_q.txsh[WORD_W-2:0], 1'b0};
            end else begin
                frm_d.sdo = 1'b0;
            end
            frm_d.fsync = (frm_q.mode == FS_LATE) ? data_nx : (slot_nx == '0);
        end

        if (fall_i && data_now) begin
            frm_d.rxsh = {frm_q.rxsh[WORD_W-2:0], sdi_i};
            if (frm_q.slot == SLOT_W'(WORD_W)) begin
                frm_d.rx_word  = {frm_q.rxsh[WORD_W-2:0], sdi_i};
                frm_d.rx_valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frm_q      <= '0;
            frm_q.slot <= SLOT_W'(FRAME_SLOTS - 1);
            frm_q.mode <= fs_mode_e'(mode_late_i);
        end else begin
            frm_q <= frm_d;
        end
    end

    assign fsync_o    = frm_q.fsync;
    assign sdo_o      = frm_q.sdo;
    assign tx_load_o  = frm_q.tx_load;
    assign rx_word_o  = frm_q.rx_word;
    assign rx_valid_o = frm_q.rx_valid;

    p_load_at_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load_o |-> (sclk_i && frm_q.slot == '0));
    p_fsync_early_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fsync_o && frm_q.mode == FS_EARLY) |-> (frm_q.slot == '0));
    p_fsync_late_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fsync_o && frm_q.mode == FS_LATE) |->
            (frm_q.slot != '0 && frm_q.slot <= SLOT_W'(WORD_W)));
    p_sdo_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_q.slot == '0 || frm_q.slot > SLOT_W'(WORD_W)) |-> !sdo_o);
    p_rx_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);
    p_mode_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(frm_q.mode));
endmodule

// File: rtl/sport_frame_master.sv
module sport_frame_master #(
    parameter int DIV         = 18,
    parameter int WORD_W      = 16,
    parameter int FRAME_SLOTS = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_late_i,
    input  logic [WORD_W-1:0] tx_word_i,
    output logic              tx_load_o,
    output logic [WORD_W-1:0] rx_word_o,
    output logic              rx_valid_o,
    output logic              sclk_o,
    output logic              fsync_o,
    output logic              sdo_o,
    input  logic              sdi_i
);
    logic rise_w;
    logic fall_w;

    sport_clkdiv #(.DIV(DIV)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_o (sclk_o),
        .rise_o (rise_w),
        .fall_o (fall_w)
    );

    sport_framer #(.WORD_W(WORD_W), .FRAME_SLOTS(FRAME_SLOTS)) u_frm (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_late_i (mode_late_i),
        .rise_i      (rise_w),
        .fall_i      (fall_w),
        .sclk_i      (sclk_o),
        .tx_word_i   (tx_word_i),
        .sdi_i       (sdi_i),
        .fsync_o     (fsync_o),
        .sdo_o       (sdo_o),
        .tx_load_o   (tx_load_o),
        .rx_word_o   (rx_word_o),
        .rx_valid_o  (rx_valid_o)
    );

    p_reset_quiet_r9: assert property (@(posedge clk)
        !rst_n |-> (!sclk_o && !fsync_o && !sdo_o && !tx_load_o && !rx_valid_o));
endmodule

// File: tb/sport_frame_master_test.sv
module sport_frame_master_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_late_i = 1'b0;
    logic [15:0] tx_word_i = 16'h0;
    logic        sdi_i = 1'b0;
    logic        tx_load_o, rx_valid_o, sclk_o, fsync_o, sdo_o;
    logic [15:0] rx_word_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    sport_frame_master uut (
        .clk(clk), .rst_n(rst_n), .mode_late_i(mode_late_i),
        .tx_word_i(tx_word_i), .tx_load_o(tx_load_o),
        .rx_word_o(rx_word_o), .rx_valid_o(rx_valid_o),
        .sclk_o(sclk_o), .fsync_o(fsync_o), .sdo_o(sdo_o), .sdi_i(sdi_i)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int slot_of(input int c);
        return (c / 18) % 256;
    endfunction

    task automatic run_mode(input bit late, input int ncyc);
        logic [15:0] frame_word;
        logic [15:0] acc;
        logic [15:0] exp_rx;
        bit          exp_sclk, exp_fs, exp_sdo, exp_ld, exp_rv;
        int          s;
        rst_n = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            mode_late_i = ~late ^ i[0];
            chk(!sclk_o && !fsync_o && !sdo_o && !tx_load_o && !rx_valid_o
                && rx_word_o == 16'h0, "R9", "reset outputs",
                {sclk_o, fsync_o, sdo_o, tx_load_o, rx_valid_o} | rx_word_o, 0);
        end
        mode_late_i = late;
        frame_word = 16'(16'h8001 ^ ($urandom & 16'hFFFE));
        tx_word_i  = frame_word;
        sdi_i      = 1'($urandom);
        acc        = 16'h0;
        exp_rx     = 16'h0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < ncyc; c++) begin
            @(negedge clk);
            s        = slot_of(c);
            exp_sclk = (c % 18) < 9;
            exp_fs   = late ? (s >= 1 && s <= 16) : (s == 0);
            exp_sdo  = (s >= 1 && s <= 16) ? frame_word[16 - s] : 1'b0;
            exp_ld   = (c % 4608) == 0;
            exp_rv   = (c % 18) == 9 && s == 16;
            chk(sclk_o == exp_sclk, "R1", "sclk", sclk_o, exp_sclk);
            chk(tx_load_o == exp_ld, "R2", "tx_load", tx_load_o, exp_ld);
            if (s >= 1 && s <= 16)
                chk(sdo_o == exp_sdo, "R3", "sdo data", sdo_o, exp_sdo);
            else
                chk(sdo_o == 1'b0, "R6", "sdo idle", sdo_o, 0);
            chk(fsync_o == exp_fs, late ? "R5" : "R4", "fsync", fsync_o, exp_fs);
            chk(rx_valid_o == exp_rv, "R7", "rx_valid", rx_valid_o, exp_rv);
            chk(rx_word_o == exp_rx, "R7", "rx_word", rx_word_o, exp_rx);
            if (c > 3) mode_late_i = 1'($urandom);   // R8: pin ignored after reset
            tx_word_i = 16'($urandom);
            sdi_i     = 1'($urandom);
            if ((c + 1) % 4608 == 0) frame_word = tx_word_i;
            if ((c + 1) % 18 == 9 && slot_of(c + 1) >= 1 && slot_of(c + 1) <= 16) begin
                acc = {acc[14:0], sdi_i};
                if (slot_of(c + 1) == 16) exp_rx = acc;
            end
        end
    endtask

    initial begin
        run_mode(1'b0, 2 * 4608 + 400);
        chk(1'b1, "R8", "early style run finished", 0, 0);
        run_mode(1'b1, 2 * 4608 + 400);
        chk(1'b1, "R8", "late style run finished", 0, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(200000 * 20);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule